// File: doc/BRIEF.md
# Threshold-Gated Transmit Beat Buffer

This block sits between a DMA engine that fills it and a MAC protocol engine that empties it. Each stored beat is 64 data bits plus a start flag, an end flag and a 3-bit byte count. The write side tells the DMA when there is room for a whole burst. The read side holds back the first beat of a packet until enough of that packet is buffered, so the engine is unlikely to run dry partway through.

While a packet is being sent, the beats from its start up to a programmable depth stay in storage. A transmission that fails early can then be restarted from its first beat. If the buffer runs empty in the middle of a packet, the result depends on a mode pin. In plain mode the packet is aborted and a sticky error is raised. In encoded mode the read port marks idle cycles and waits for data.

Both data ports use valid/ready handshakes. A write is taken on a clock edge where `wr_valid` and `wr_ready` are both high. The writer may hold `wr_valid` high for as long as it likes. Once `rd_valid` is high, the beat on the read port does not change until `rd_ready` takes it. The only things that can move the read port before then are an accepted retry request and a flush. The reader may hold `rd_ready` low for any number of cycles.

Top module: `txf_fifo`

## Requirements
- R1: Beats leave the read port in write order. Each keeps its data, start flag, end flag and byte count unchanged. A byte count of 0 means all 8 bytes are valid.
- R2: With DEPTH beats counted as occupied, `wr_ready` is low and any write attempt is discarded.
- R3: `dma_req` is high exactly when the number of free beats is at least `thr_wr`.
- R4: Outside a packet, the head beat is offered only once at least `thr_rd` beats are stored, or once some stored beat carries the end flag.
- R5: While `rd_valid` is high and `rd_ready` is low, the beat on the read port stays the same on the next cycle.
- R6: In plain mode (`mode_encoded`=0), if storage is empty after a packet's first beat is read and before its last beat is read, `underflow` is set. The remaining beats of that packet, up to and including the one with the end flag, are then discarded without being offered. `underflow` stays set until a flush.
- R7: In encoded mode (`mode_encoded`=1), the same empty condition drives `rd_idle` high and `rd_valid` low. `underflow` is not set, and the packet continues once data arrives.
- R8: A `retry_req` pulse is accepted while a packet is in progress and fewer than `thr_retry` of its beats have been read. It rewinds the read port, so the next beat offered is that packet's first beat.
- R9: A `retry_req` outside that window sets `retry_fail`, which stays set until a flush, and leaves the read position unchanged.
- R10: While the retry window is open, the beats already read from the current packet still count as occupied for `wr_ready` and `dma_req`.
- R11: A `flush` cycle empties storage, discards all stored beats and clears `underflow` and `retry_fail`.
- R12: After reset, `rd_valid`, `rd_idle`, `underflow` and `retry_fail` are low, and `wr_ready` and `dma_req` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of storage and flags |
| mode_encoded | input | 1 | 1: empty mid-packet gives idle cycles; 0: aborts with underflow |
| thr_wr | input | $clog2(DEPTH)+1 | Free beats needed for a DMA request |
| thr_rd | input | $clog2(DEPTH)+1 | Stored beats needed before a first beat is offered |
| thr_retry | input | $clog2(DEPTH)+1 | Retry window length in beats read |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Room for one beat |
| wr_data | input | 64 | Write beat data |
| wr_sop | input | 1 | Write beat is a packet start |
| wr_eop | input | 1 | Write beat is a packet end |
| wr_bcnt | input | 3 | Valid bytes, 0 means 8 |
| dma_req | output | 1 | Request a burst from the DMA |
| rd_valid | output | 1 | Read beat valid |
| rd_ready | input | 1 | Engine takes the read beat |
| rd_data | output | 64 | Read beat data |
| rd_sop | output | 1 | Read beat is a packet start |
| rd_eop | output | 1 | Read beat is a packet end |
| rd_bcnt | output | 3 | Read beat byte count |
| rd_idle | output | 1 | Encoded-mode idle cycle inside a packet |
| retry_req | input | 1 | Restart current packet from its first beat |
| underflow | output | 1 | Sticky mid-packet empty error |
| retry_fail | output | 1 | Sticky retry-outside-window flag |

## Verification
Some properties are checked by assertions on every cycle. Occupancy never goes above the depth. The offered beat is held stable while the reader stalls. A burst request never appears when a write could not be taken. The underflow flag stays set, and it never rises in encoded mode. An accepted retry reloads the saved start position, and a refused one raises the fail flag.

Other behaviour only shows up in the bench scenarios:
- whole packets coming out in order;
- holding back a short or long first beat;
- the exact free count at which the request drops, and how the retry window adds to it;
- the discarded remainder of an aborted packet;
- a flush removing stored beats.

// File: rtl/txf_pkg.sv
package txf_pkg;
  localparam int unsigned BEAT_W = 64;
  localparam int unsigned BCNT_W = 3;

  typedef struct packed {
    logic              sop;
    logic              eop;
    logic [BCNT_W-1:0] bcnt;
    logic [BEAT_W-1:0] data;
  } txf_beat_t;

  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_SEND = 2'd1,
    RD_DROP = 2'd2
  } txf_rd_state_e;
endpackage

// File: rtl/txf_mem.sv
module txf_mem import txf_pkg::*; #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned AW    = 7
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  txf_beat_t       wr_beat,
  input  logic [AW-1:0]   rd_addr,
  output txf_beat_t       rd_beat
);
  txf_beat_t slots [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_addr] <= wr_beat;
  end

  assign rd_beat = slots[rd_addr];
endmodule

// File: rtl/txf_rd_ctrl.sv
module txf_rd_ctrl import txf_pkg::*; #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          mode_encoded,
  input  logic [CW-1:0] thr_rd,
  input  logic [CW-1:0] thr_retry,
  input  logic [CW-1:0] level,
  input  logic          eop_avail,
  input  logic          head_eop,
  input  logic [CW-1:0] rptr,
  input  logic          rd_ready,
  input  logic          retry_req,
  output logic          rd_valid,
  output logic          rd_idle,
  output logic          pop,
  output logic          rewind,
  output logic          window_open,
  output logic [CW-1:0] sop_ptr,
  output logic          underflow,
  output logic          retry_fail
);
  txf_rd_state_e state_q, state_d;
  logic [CW-1:0] sop_q, rd_done;
  logic have_head, start_ok, accept, drop_pop, set_uf;

  always_comb begin
    have_head   = (level != '0);
    start_ok    = have_head && ((level >= thr_rd) || eop_avail);
    rd_done     = rptr - sop_q;
    window_open = (state_q == RD_SEND) && (rd_done < thr_retry);
    rewind      = retry_req && window_open;
    rd_valid    = ((state_q == RD_IDLE) && start_ok) ||
                  ((state_q == RD_SEND) && have_head);
    rd_idle     = (state_q == RD_SEND) && !have_head && mode_encoded;
    accept      = rd_valid && rd_ready;
    drop_pop    = (state_q == RD_DROP) && have_head;
    pop         = (accept || drop_pop) && !rewind;
    set_uf      = 1'b0;
    state_d     = state_q;
    case (state_q)
      RD_IDLE: if (accept && !head_eop) state_d = RD_SEND;
      RD_SEND: begin
        if (rewind)                        state_d = RD_IDLE;
        else if (accept && head_eop)       state_d = RD_IDLE;
        else if (!have_head && !mode_encoded) begin
          state_d = RD_DROP;
          set_uf  = 1'b1;
        end
      end
      RD_DROP: if (drop_pop && head_eop) state_d = RD_IDLE;
      default: state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= RD_IDLE;
      sop_q      <= '0;
      underflow  <= 1'b0;
      retry_fail <= 1'b0;
    end else if (flush) begin
      state_q    <= RD_IDLE;
      sop_q      <= '0;
      underflow  <= 1'b0;
      retry_fail <= 1'b0;
    end else begin
      state_q <= state_d;
      if ((state_q == RD_IDLE) && accept) sop_q <= rptr;
      if (set_uf) underflow <= 1'b1;
      if (retry_req && !window_open) retry_fail <= 1'b1;
    end
  end

  assign sop_ptr = sop_q;

  assert_underflow_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    underflow && !flush |=> underflow);

  assert_no_underflow_encoded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underflow) |-> !$past(mode_encoded));

  assert_retry_reloads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rewind && !flush |=> rptr == $past(sop_q));

  assert_retry_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req && !window_open && !flush |=> retry_fail);
endmodule

// File: rtl/txf_fifo.sv
module txf_fifo import txf_pkg::*; #(
  parameter int unsigned DEPTH = 128
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    mode_encoded,
  input  logic [$clog2(DEPTH):0]  thr_wr,
  input  logic [$clog2(DEPTH):0]  thr_rd,
  input  logic [$clog2(DEPTH):0]  thr_retry,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [BEAT_W-1:0]       wr_data,
  input  logic                    wr_sop,
  input  logic                    wr_eop,
  input  logic [BCNT_W-1:0]       wr_bcnt,
  output logic                    dma_req,
  output logic                    rd_valid,
  input  logic                    rd_ready,
  output logic [BEAT_W-1:0]       rd_data,
  output logic                    rd_sop,
  output logic                    rd_eop,
  output logic [BCNT_W-1:0]       rd_bcnt,
  output logic                    rd_idle,
  input  logic                    retry_req,
  output logic                    underflow,
  output logic                    retry_fail
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [CW-1:0] wptr_q, rptr_q, eop_q, sop_ptr, hold_ptr, level, used, free_cnt;
  logic wr_fire, pop, rewind, window_open;
  txf_beat_t in_beat, head;

  assign in_beat  = '{sop: wr_sop, eop: wr_eop, bcnt: wr_bcnt, data: wr_data};
  assign level    = wptr_q - rptr_q;
  assign hold_ptr = window_open ? sop_ptr : rptr_q;
  assign used     = wptr_q - hold_ptr;
  assign free_cnt = DEPTH_C - used;
  assign wr_ready = (free_cnt != '0);
  assign wr_fire  = wr_valid && wr_ready && !flush;
  assign dma_req  = (free_cnt >= thr_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      eop_q  <= '0;
    end else if (flush) begin
      wptr_q <= '0;
      rptr_q <= '0;
      eop_q  <= '0;
    end else begin
      if (wr_fire) wptr_q <= wptr_q + CW'(1);
      if (rewind)   rptr_q <= sop_ptr;
      else if (pop) rptr_q <= rptr_q + CW'(1);
      eop_q <= eop_q + CW'(wr_fire && wr_eop) - CW'(pop && head.eop);
    end
  end

  txf_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk     (clk),
    .wr_en   (wr_fire),
    .wr_addr (wptr_q[AW-1:0]),
    .wr_beat (in_beat),
    .rd_addr (rptr_q[AW-1:0]),
    .rd_beat (head)
  );

  txf_rd_ctrl #(.CW(CW)) u_rd (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .mode_encoded (mode_encoded),
    .thr_rd       (thr_rd),
    .thr_retry    (thr_retry),
    .level        (level),
    .eop_avail    (eop_q != '0),
    .head_eop     (head.eop),
    .rptr         (rptr_q),
    .rd_ready     (rd_ready),
    .retry_req    (retry_req),
    .rd_valid     (rd_valid),
    .rd_idle      (rd_idle),
    .pop          (pop),
    .rewind       (rewind),
    .window_open  (window_open),
    .sop_ptr      (sop_ptr),
    .underflow    (underflow),
    .retry_fail   (retry_fail)
  );

  assign rd_data = head.data;
  assign rd_sop  = head.sop;
  assign rd_eop  = head.eop;
  assign rd_bcnt = head.bcnt;

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    used <= DEPTH_C);

  assert_req_has_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && (thr_wr != '0) |-> wr_ready);

  assert_hold_until_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !flush && !retry_req |=>
      rd_valid && $stable(rd_data) && $stable(rd_sop) && $stable(rd_eop) && $stable(rd_bcnt));
endmodule

// File: tb/test_txf_fifo.sv
`timescale 1ns/1ps
module test_txf_fifo;
  import txf_pkg::*;
  localparam int unsigned DEPTH = 128;
  localparam int unsigned CW = 8;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, mode_encoded = 1'b0;
  logic [CW-1:0] thr_wr = 8'd8, thr_rd = 8'd4, thr_retry = 8'd4;
  logic wr_valid = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0, rd_ready = 1'b0, retry_req = 1'b0;
  logic [63:0] wr_data = '0;
  logic [2:0] wr_bcnt = '0;
  logic wr_ready, dma_req, rd_valid, rd_sop, rd_eop, rd_idle, underflow, retry_fail;
  logic [63:0] rd_data;
  logic [2:0] rd_bcnt;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  txf_beat_t exp_q[$];

  always #5 clk = ~clk;

  txf_fifo #(.DEPTH(DEPTH)) i_txf_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .mode_encoded(mode_encoded),
    .thr_wr(thr_wr), .thr_rd(thr_rd), .thr_retry(thr_retry),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_sop(wr_sop),
    .wr_eop(wr_eop), .wr_bcnt(wr_bcnt), .dma_req(dma_req),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_sop(rd_sop),
    .rd_eop(rd_eop), .rd_bcnt(rd_bcnt), .rd_idle(rd_idle), .retry_req(retry_req),
    .underflow(underflow), .retry_fail(retry_fail)
  );

  task automatic chk(input string req, input string what, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic txf_beat_t mk(input int pkt, input int idx, input bit s, input bit e);
    txf_beat_t b;
    b.sop  = s;
    b.eop  = e;
    b.bcnt = 3'((pkt + idx) % 8);
    b.data = {32'(pkt), 32'(idx)} ^ 64'h5A5A_0F0F_3C3C_9696;
    return b;
  endfunction

  task automatic push(input txf_beat_t b, input bit keep);
    @(posedge clk); #2;
    wr_valid = 1'b1; wr_data = b.data; wr_sop = b.sop; wr_eop = b.eop; wr_bcnt = b.bcnt;
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    @(posedge clk); #2;
    wr_valid = 1'b0;
    if (keep) exp_q.push_back(b);
  endtask

  task automatic push_pkt(input int pkt, input int n, input bit keep);
    for (int k = 0; k < n; k++) push(mk(pkt, k, k == 0, k == n - 1), keep);
  endtask

  task automatic read_beats(input int n);
    @(posedge clk); #2; rd_ready = 1'b1;
    repeat (n) @(posedge clk);
    #2; rd_ready = 1'b0;
  endtask

  task automatic drain(input string req);
    @(posedge clk); #2; rd_ready = 1'b1;
    for (int i = 0; i < 600 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (4) @(posedge clk);
    #2; rd_ready = 1'b0;
    chk(req, "beats left unread", 72'(exp_q.size()), 72'd0);
    chk(req, "no extra beat after drain", 72'(rd_valid), 72'd0);
  endtask

  task automatic pulse_flush();
    @(posedge clk); #2; flush = 1'b1;
    @(posedge clk); #2; flush = 1'b0;
    exp_q.delete();
  endtask

  task automatic pulse_retry();
    @(posedge clk); #2; retry_req = 1'b1;
    @(posedge clk); #2; retry_req = 1'b0;
  endtask

  // Scoreboard monitor: R1 order and content of every taken beat
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !flush && rd_valid && rd_ready) begin
        txf_beat_t got;
        got.sop = rd_sop; got.eop = rd_eop; got.bcnt = rd_bcnt; got.data = rd_data;
        if (exp_q.size() == 0) chk("R1", "unexpected beat", {3'b0, got}, 72'd0);
        else begin
          txf_beat_t e;
          e = exp_q.pop_front();
          chk("R1", "beat content/order", {3'b0, got}, {3'b0, e});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2; rst_n = 1'b1;
    @(posedge clk); #2;
    // R12 reset state
    chk("R12", "rd_valid", 72'(rd_valid), 72'd0);
    chk("R12", "rd_idle", 72'(rd_idle), 72'd0);
    chk("R12", "wr_ready", 72'(wr_ready), 72'd1);
    chk("R12", "dma_req", 72'(dma_req), 72'd1);
    chk("R12", "flags", {70'd0, underflow, retry_fail}, 72'd0);

    // R4 start gating by fill level, R5 hold while stalled
    push(mk(1, 0, 1, 0), 1); push(mk(1, 1, 0, 0), 1); push(mk(1, 2, 0, 0), 1);
    repeat (3) @(posedge clk); #2;
    chk("R4", "held below thr_rd", 72'(rd_valid), 72'd0);
    push(mk(1, 3, 0, 0), 1);
    chk("R4", "offered at thr_rd", 72'(rd_valid), 72'd1);
    chk("R4", "first beat data", 72'(rd_data), 72'(mk(1, 0, 1, 0).data));
    repeat (2) @(posedge clk); #2;
    chk("R5", "stalled beat stable", {7'd0, rd_valid, rd_data}, {7'd0, 1'b1, mk(1, 0, 1, 0).data});
    push(mk(1, 4, 0, 0), 1); push(mk(1, 5, 0, 1), 1);
    drain("R1");

    // R4 short packet released by its end beat
    push(mk(2, 0, 1, 0), 1); push(mk(2, 1, 0, 1), 1);
    chk("R4", "end beat bypasses thr_rd", 72'(rd_valid), 72'd1);
    drain("R1");

    // R2/R3 fill to the top
    for (int k = 0; k < DEPTH; k++) begin
      push(mk(3, k, k == 0, k == DEPTH - 1), 1);
      if (k == DEPTH - 9) chk("R3", "request at 8 free", 72'(dma_req), 72'd1);
      if (k == DEPTH - 8) chk("R3", "no request at 7 free", 72'(dma_req), 72'd0);
    end
    chk("R2", "wr_ready when full", 72'(wr_ready), 72'd0);
    @(posedge clk); #2;
    wr_valid = 1'b1; wr_data = 64'hDEAD; wr_sop = 1'b1; wr_eop = 1'b1;
    repeat (3) @(posedge clk);
    #2; wr_valid = 1'b0;
    chk("R2", "still full after refused write", 72'(wr_ready), 72'd0);
    drain("R2");

    // R6 underflow in plain mode
    thr_rd = 8'd2;
    @(posedge clk); #2; rd_ready = 1'b1;
    push(mk(4, 0, 1, 0), 1); push(mk(4, 1, 0, 0), 1);
    repeat (4) @(posedge clk); #2;
    chk("R6", "underflow set", 72'(underflow), 72'd1);
    push(mk(4, 2, 0, 0), 0); push(mk(4, 3, 0, 1), 0);
    push_pkt(5, 2, 1);
    drain("R6");
    chk("R6", "underflow sticky", 72'(underflow), 72'd1);
    pulse_flush();
    chk("R11", "underflow cleared", 72'(underflow), 72'd0);
    chk("R11", "empty after flush", {70'd0, rd_valid, wr_ready}, 72'd1);

    // R7 encoded mode idle cycles
    mode_encoded = 1'b1;
    @(posedge clk); #2; rd_ready = 1'b1;
    push(mk(6, 0, 1, 0), 1); push(mk(6, 1, 0, 0), 1);
    repeat (3) @(posedge clk); #2;
    chk("R7", "idle marker, no valid", {70'd0, rd_idle, rd_valid}, 72'd2);
    chk("R7", "no underflow", 72'(underflow), 72'd0);
    push(mk(6, 2, 0, 0), 1); push(mk(6, 3, 0, 1), 1);
    drain("R7");
    chk("R7", "idle ends with packet", {70'd0, rd_idle, underflow}, 72'd0);
    mode_encoded = 1'b0;

    // R8/R10 retry inside window
    push_pkt(7, 6, 1);
    read_beats(2);
    thr_wr = 8'd123;
    #1 chk("R10", "read beats still held", 72'(dma_req), 72'd0);
    thr_wr = 8'd122;
    #1 chk("R10", "free equals 122", 72'(dma_req), 72'd1);
    thr_wr = 8'd123;
    exp_q.push_front(mk(7, 1, 0, 0));
    exp_q.push_front(mk(7, 0, 1, 0));
    pulse_retry();
    chk("R8", "no retry_fail", 72'(retry_fail), 72'd0);
    chk("R8", "first beat offered again", {7'd0, rd_valid, rd_data}, {7'd0, 1'b1, mk(7, 0, 1, 0).data});
    read_beats(4);
    chk("R10", "window closed frees beats", 72'(dma_req), 72'd1);
    thr_wr = 8'd8;
    drain("R8");

    // R9 retry outside window
    push_pkt(8, 6, 1);
    read_beats(5);
    pulse_retry();
    chk("R9", "retry_fail set", 72'(retry_fail), 72'd1);
    chk("R9", "position unchanged", {7'd0, rd_valid, rd_data}, {7'd0, 1'b1, mk(8, 5, 0, 1).data});
    drain("R9");
    chk("R9", "retry_fail sticky", 72'(retry_fail), 72'd1);
    pulse_flush();
    chk("R11", "retry_fail cleared", 72'(retry_fail), 72'd0);

    // R11 flush discards stored beats
    push_pkt(9, 3, 0);
    pulse_flush();
    chk("R11", "nothing offered after flush", 72'(rd_valid), 72'd0);
    chk("R11", "room restored", {70'd0, wr_ready, dma_req}, 72'd3);
    push_pkt(10, 2, 1);
    drain("R11");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule